// File: doc/BRIEF.md
# Burst DMA Engine with Register-Mapped Control

This block moves words between a private 4096-word drive store and the processor's main data memory. Software sets it up with ordinary data-memory accesses. Three low data addresses are claimed by the engine instead of main memory: a control word, a drive word pointer and a memory word pointer. The control word holds the transfer direction in its lowest bit and the number of words still to move in the bits above it.

After write-back of every instruction, the processor signals an interrupt phase with a one-cycle pulse. If words remain, the engine holds the processor stalled and moves a burst of at most four words. Each word uses a one-word handshake with main memory. After each word the count drops by one and both pointers advance. The stall is released in the cycle that the last word of the burst completes. The processor therefore sees a transfer progress over several instructions, and it detects completion by polling the count.

Every word the engine writes into main memory is announced on a snoop-invalidate output, so that a cache can drop the matching line. After reset the drive store is swept to all-ones over one cycle per word. An interrupt phase that arrives during the sweep is held until the sweep ends.

Top module: `dma_burst_engine`

## Requirements
- R1: After reset the control word, drive pointer and memory pointer all read as zero, and neither `cpu_stall` nor `mem_req` is asserted.
- R2: `cpu_hit` is high exactly when `cpu_req` is high and `cpu_addr` is 0, 1 or 2. A write at address 0 sets the control word, at address 1 the drive pointer (low 12 bits kept) and at address 2 the memory pointer. Reads at these addresses return the live register value combinationally. Any other address leaves the registers untouched.
- R3: Control bit 0 selects the direction. A 0 copies drive words into main memory (`mem_we`=1). A 1 copies main memory words into the drive (`mem_we`=0).
- R4: Control bits [15:1] hold the remaining word count. The count drops by one for every word moved, so a read of address 0 shows the words still outstanding, and it reads 0 (direction bit kept) when the transfer is finished.
- R5: When an interrupt phase starts with a non-zero count, the engine moves min(4, count) words and then pulses `phase_done`. `cpu_stall` is high from the phase's first cycle through the cycle of the last word.
- R6: When an interrupt phase starts with a count of zero (and no sweep is running), `phase_done` is high in that same cycle and `cpu_stall` stays low.
- R7: After each word, both pointers increase by one. The drive pointer wraps from 4095 to 0.
- R8: After reset every drive word holds 16'hFFFF.
- R9: Every word written into main memory raises `snoop_inv` in its completing cycle, with `snoop_addr` equal to that word's memory address. Transfers toward the drive raise no snoop.
- R10: CPU writes at addresses 0 to 2 while a burst is moving words have no effect.
- R11: Each word waits for `mem_ack`. With w wait cycles per word, a burst of n words stalls the processor for 1 + n·(w+1) cycles.
- R12: An interrupt phase that starts during the post-reset sweep keeps `cpu_stall` high until the sweep completes. The burst then runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Processor data access valid |
| cpu_we | input | 1 | Processor access is a write |
| cpu_addr | input | 16 | Processor data word address |
| cpu_wdata | input | 16 | Processor write data |
| cpu_hit | output | 1 | Access claimed by the engine (addresses 0 to 2) |
| cpu_rdata | output | 16 | Register read data |
| irq_phase | input | 1 | One-cycle pulse: interrupt phase begins |
| cpu_stall | output | 1 | Processor must hold |
| phase_done | output | 1 | Interrupt phase finished this cycle |
| mem_req | output | 1 | Main memory access request |
| mem_we | output | 1 | Main memory access is a write |
| mem_addr | output | 16 | Main memory word address |
| mem_wdata | output | 16 | Word written to main memory |
| mem_rdata | input | 16 | Word read from main memory |
| mem_ack | input | 1 | Main memory access completes this cycle |
| snoop_inv | output | 1 | Invalidate request toward the cache |
| snoop_addr | output | 16 | Address to invalidate |

## Verification
The bench goes after the burst boundary at four words. A design that moved the whole count at once, or capped the burst at the wrong point, would leave a wrong remainder in the control word and a wrong stall length. It also tests a zero-count phase, where a faulty engine would stall or fail to signal completion in the same cycle. Drive-pointer wraparound at 4095 is covered: carrying into an unused bit would send the third word to the wrong drive slot. A control write during a burst must be ignored; obeying it would corrupt the count. Two further cases close the set: a phase issued during the reset sweep, which must neither run early nor copy unswept data, and wait states on memory, which must stretch the stall rather than let words be skipped or duplicated.

// File: rtl/dma_pkg.sv
package dma_pkg;

  // number of engine registers claimed at the bottom of data memory
  localparam int unsigned NUM_REGS = 3;
  localparam logic [1:0]  REG_CTRL = 2'd0;
  localparam logic [1:0]  REG_DPTR = 2'd1;
  localparam logic [1:0]  REG_MPTR = 2'd2;

  typedef enum logic [1:0] {
    ST_SWEEP = 2'd0,
    ST_IDLE  = 2'd1,
    ST_MOVE  = 2'd2
  } dma_state_e;

  // words moved in one phase: the smaller of what remains and the cap
  function automatic int unsigned burst_words(int unsigned remaining,
                                              int unsigned cap);
    return (remaining < cap) ? remaining : cap;
  endfunction

  // control word image: direction in bit 0, count above it
  function automatic logic [31:0] ctrl_image(logic dir, logic [30:0] cnt);
    return {cnt, dir};
  endfunction

endpackage

// File: rtl/dma_regfile.sv
module dma_regfile #(
  parameter int DW     = 16,
  parameter int MAW    = 16,
  parameter int DAW    = 12,
  parameter int CPU_AW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [DW-1:0]     cpu_wdata,
  output logic              cpu_hit,
  output logic [DW-1:0]     cpu_rdata,
  input  logic              lock,
  input  logic              word_done,
  output logic              dir,
  output logic [DW-2:0]     cnt,
  output logic [DAW-1:0]    drv_ptr,
  output logic [MAW-1:0]    mem_ptr
);
  import dma_pkg::*;

  localparam int CW = DW - 1;

  logic          dir_q;
  logic [CW-1:0] cnt_q;
  logic [DAW-1:0] drv_q;
  logic [MAW-1:0] mem_q;
  logic          sel;
  logic          wr_ok;

  assign sel   = cpu_req && (cpu_addr < CPU_AW'(NUM_REGS));
  assign wr_ok = sel && cpu_we && !lock;
  assign cpu_hit = sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= 1'b0;
      cnt_q <= '0;
      drv_q <= '0;
      mem_q <= '0;
    end else if (word_done) begin
      cnt_q <= cnt_q - 1'b1;
      drv_q <= drv_q + 1'b1;
      mem_q <= mem_q + 1'b1;
    end else if (wr_ok) begin
      case (cpu_addr[1:0])
        REG_CTRL: begin
          dir_q <= cpu_wdata[0];
          cnt_q <= cpu_wdata[DW-1:1];
        end
        REG_DPTR: drv_q <= cpu_wdata[DAW-1:0];
        REG_MPTR: mem_q <= MAW'(cpu_wdata);
        default: ;
      endcase
    end
  end

  always_comb begin
    cpu_rdata = '0;
    if (sel) begin
      case (cpu_addr[1:0])
        REG_CTRL: cpu_rdata = DW'(ctrl_image(dir_q, 31'(cnt_q)));
        REG_DPTR: cpu_rdata = DW'(drv_q);
        REG_MPTR: cpu_rdata = DW'(mem_q);
        default:  cpu_rdata = '0;
      endcase
    end
  end

  assign dir     = dir_q;
  assign cnt     = cnt_q;
  assign drv_ptr = drv_q;
  assign mem_ptr = mem_q;

  AST_NO_COUNT_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |-> cnt_q != '0); // R4
  AST_COUNT_STEPS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> cnt_q == $past(cnt_q) - 1'b1); // R4
  AST_LOCKED_CTRL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && !word_done) |=> ($stable(cnt_q) && $stable(dir_q))); // R10

endmodule

// File: rtl/dma_drive_store.sv
module dma_drive_store #(
  parameter int DW  = 16,
  parameter int DAW = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [DAW-1:0] wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic [DAW-1:0] rd_addr,
  output logic [DW-1:0]  rd_data,
  output logic           sweep_busy
);
  localparam int DEPTH = 1 << DAW;

  logic [DW-1:0]  store [DEPTH];
  logic [DAW-1:0] sweep_ptr;
  logic           sweep_q;
  logic           sweep_last;

  assign sweep_last = (sweep_ptr == DAW'(DEPTH - 1));

  // post-reset fill walks one word per cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sweep_ptr <= '0;
      sweep_q   <= 1'b1;
    end else if (sweep_q) begin
      sweep_ptr <= sweep_ptr + 1'b1;
      if (sweep_last) sweep_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (sweep_q) store[sweep_ptr] <= '1;
    else if (wr_en) store[wr_addr] <= wr_data;
  end

  assign rd_data    = store[rd_addr];
  assign sweep_busy = sweep_q;

  AST_NO_WRITE_IN_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_q |-> !wr_en); // R12

endmodule

// File: rtl/dma_burst_fsm.sv
module dma_burst_fsm #(
  parameter int CW        = 15,
  parameter int MAX_BURST = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sweep_busy,
  input  logic          irq_phase,
  input  logic [CW-1:0] cnt,
  input  logic          dir,
  input  logic          mem_ack,
  output logic          moving,
  output logic          idle,
  output logic          word_done,
  output logic          phase_done,
  output logic          cpu_stall,
  output logic          mem_req,
  output logic          mem_we,
  output logic          drv_we
);
  import dma_pkg::*;

  localparam int BW = $clog2(MAX_BURST + 1);

  dma_state_e    state_q, state_d;
  logic [BW-1:0] left_q, left_d;
  logic [BW-1:0] phase_words_q;
  logic          pend_q, pend_d;
  logic          start_req;
  logic          cnt_zero;

  assign start_req = irq_phase || pend_q;
  assign cnt_zero  = (cnt == '0);

  always_comb begin
    state_d    = state_q;
    left_d     = left_q;
    pend_d     = pend_q;
    phase_done = 1'b0;
    word_done  = 1'b0;
    mem_req    = 1'b0;
    mem_we     = 1'b0;
    drv_we     = 1'b0;
    cpu_stall  = 1'b0;
    case (state_q)
      ST_SWEEP: begin
        if (irq_phase) pend_d = 1'b1;
        cpu_stall = start_req;
        if (!sweep_busy) state_d = ST_IDLE;
      end
      ST_IDLE: begin
        if (start_req) begin
          pend_d = 1'b0;
          if (cnt_zero) begin
            phase_done = 1'b1;
          end else begin
            cpu_stall = 1'b1;
            left_d    = BW'(burst_words(int'(cnt), MAX_BURST));
            state_d   = ST_MOVE;
          end
        end
      end
      ST_MOVE: begin
        cpu_stall = 1'b1;
        mem_req   = 1'b1;
        mem_we    = !dir;
        if (mem_ack) begin
          word_done = 1'b1;
          drv_we    = dir;
          left_d    = left_q - 1'b1;
          if (left_q == BW'(1)) begin
            phase_done = 1'b1;
            state_d    = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_SWEEP;
      left_q  <= '0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      left_q  <= left_d;
      pend_q  <= pend_d;
    end
  end

  // words moved in the current phase, kept for the burst-cap check
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_words_q <= '0;
    else if (state_q != ST_MOVE) phase_words_q <= '0;
    else if (word_done) phase_words_q <= phase_words_q + 1'b1;
  end

  assign moving = (state_q == ST_MOVE);
  assign idle   = (state_q == ST_IDLE);

  AST_BURST_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    phase_words_q <= BW'(MAX_BURST)); // R5
  AST_MOVE_NEEDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    moving |-> !cnt_zero); // R4
  AST_DONE_RETURNS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_done && moving) |=> idle); // R5
  AST_STALL_WHILE_MOVING: assert property (@(posedge clk) disable iff (!rst_n)
    (moving && !phase_done) |=> cpu_stall); // R5

endmodule

// File: rtl/dma_burst_engine.sv
module dma_burst_engine #(
  parameter int DW        = 16,
  parameter int CPU_AW    = 16,
  parameter int MAW       = 16,
  parameter int DAW       = 12,
  parameter int MAX_BURST = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [DW-1:0]     cpu_wdata,
  output logic              cpu_hit,
  output logic [DW-1:0]     cpu_rdata,
  input  logic              irq_phase,
  output logic              cpu_stall,
  output logic              phase_done,
  output logic              mem_req,
  output logic              mem_we,
  output logic [MAW-1:0]    mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata,
  input  logic              mem_ack,
  output logic              snoop_inv,
  output logic [MAW-1:0]    snoop_addr
);
  localparam int CW = DW - 1;

  logic           dir;
  logic [CW-1:0]  cnt;
  logic [DAW-1:0] drv_ptr;
  logic [MAW-1:0] mem_ptr;
  logic           moving;
  logic           fsm_idle;
  logic           word_done;
  logic           drv_we;
  logic           sweep_busy;
  logic [DW-1:0]  drv_rdata;

  dma_regfile #(.DW(DW), .MAW(MAW), .DAW(DAW), .CPU_AW(CPU_AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .cpu_we    (cpu_we),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_hit   (cpu_hit),
    .cpu_rdata (cpu_rdata),
    .lock      (moving),
    .word_done (word_done),
    .dir       (dir),
    .cnt       (cnt),
    .drv_ptr   (drv_ptr),
    .mem_ptr   (mem_ptr)
  );

  dma_drive_store #(.DW(DW), .DAW(DAW)) u_drive (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (drv_we),
    .wr_addr    (drv_ptr),
    .wr_data    (mem_rdata),
    .rd_addr    (drv_ptr),
    .rd_data    (drv_rdata),
    .sweep_busy (sweep_busy)
  );

  dma_burst_fsm #(.CW(CW), .MAX_BURST(MAX_BURST)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .sweep_busy (sweep_busy),
    .irq_phase  (irq_phase),
    .cnt        (cnt),
    .dir        (dir),
    .mem_ack    (mem_ack),
    .moving     (moving),
    .idle       (fsm_idle),
    .word_done  (word_done),
    .phase_done (phase_done),
    .cpu_stall  (cpu_stall),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .drv_we     (drv_we)
  );

  assign mem_addr   = mem_ptr;
  assign mem_wdata  = drv_rdata;
  assign snoop_inv  = word_done && !dir;
  assign snoop_addr = mem_ptr;

  AST_SNOOP_ON_MEM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_inv |-> (mem_req && mem_we && mem_ack && snoop_addr == mem_addr)); // R9
  AST_NO_SNOOP_TO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    drv_we |-> !snoop_inv); // R9
  AST_ZERO_COUNT_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_phase && fsm_idle && cnt == '0) |-> (phase_done && !cpu_stall)); // R6
  AST_STALL_IN_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_phase && sweep_busy) |-> cpu_stall); // R12

endmodule

// File: tb/tb_dma_burst_engine.sv
module tb_dma_burst_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [15:0] cpu_addr = '0, cpu_wdata = '0;
  logic        cpu_hit;
  logic [15:0] cpu_rdata;
  logic        irq_phase = 1'b0;
  logic        cpu_stall, phase_done;
  logic        mem_req, mem_we, mem_ack;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic        snoop_inv;
  logic [15:0] snoop_addr;

  logic [15:0] bmem [256];
  int wait_cfg = 0;
  int wcnt = 0;
  int n_memwr = 0, n_memrd = 0, n_snoop = 0, n_snoop_bad = 0;
  int n_checks = 0, n_err = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dma_burst_engine dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_hit(cpu_hit),
    .cpu_rdata(cpu_rdata), .irq_phase(irq_phase), .cpu_stall(cpu_stall),
    .phase_done(phase_done), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .snoop_inv(snoop_inv), .snoop_addr(snoop_addr)
  );

  // main memory model with programmable wait cycles
  assign mem_ack   = mem_req && (wcnt >= wait_cfg);
  assign mem_rdata = bmem[mem_addr[7:0]];

  always @(posedge clk) begin
    if (!mem_req || mem_ack) wcnt <= 0;
    else wcnt <= wcnt + 1;
    if (rst_n) begin
      if (mem_req && mem_ack && mem_we) begin
        bmem[mem_addr[7:0]] <= mem_wdata;
        n_memwr <= n_memwr + 1;
      end
      if (mem_req && mem_ack && !mem_we) n_memrd <= n_memrd + 1;
      if (snoop_inv) begin
        n_snoop <= n_snoop + 1;
        if (!(mem_req && mem_we && mem_ack) || snoop_addr != mem_addr)
          n_snoop_bad <= n_snoop_bad + 1;
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  task automatic reg_wr(logic [15:0] a, logic [15:0] d);
    @(negedge clk);
    cpu_req = 1; cpu_we = 1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_req = 0; cpu_we = 0;
  endtask

  task automatic reg_rd(logic [15:0] a, output logic [15:0] d, output logic h);
    @(negedge clk);
    cpu_req = 1; cpu_we = 0; cpu_addr = a;
    #1;
    d = cpu_rdata; h = cpu_hit;
    cpu_req = 0;
  endtask

  task automatic setup(logic [15:0] dptr, logic [15:0] mptr, logic [15:0] ctrl);
    reg_wr(16'd1, dptr);
    reg_wr(16'd2, mptr);
    reg_wr(16'd0, ctrl);
  endtask

  // one interrupt phase; returns stall cycles and the cycle of phase_done
  task automatic run_phase(output int stall, output int done_at);
    bit done = 0;
    stall = 0; done_at = -1;
    @(negedge clk);
    irq_phase = 1;
    #1;
    for (int c = 0; c < 6000 && !done; c++) begin
      if (c > 0) begin
        @(negedge clk);
        irq_phase = 0;
        #1;
      end
      if (cpu_stall) stall++;
      if (phase_done) begin done = 1; done_at = c; end
    end
    irq_phase = 0;
    @(negedge clk);
  endtask

  task automatic expect_phase(string req, int words, int waitc);
    int st, da, mw0, mr0;
    mw0 = n_memwr; mr0 = n_memrd;
    run_phase(st, da);
    chk(req, st, 1 + words * (waitc + 1), "stall cycles");
    chk(req, (n_memwr - mw0) + (n_memrd - mr0), words, "words moved");
  endtask

  task automatic t_reset();
    logic [15:0] d; logic h;
    chk("R1", cpu_stall, 0, "stall after reset");
    chk("R1", mem_req, 0, "mem_req after reset");
    for (int a = 0; a < 3; a++) begin
      reg_rd(16'(a), d, h);
      chk("R1", d, 0, "register after reset");
    end
  endtask

  task automatic t_sweep_phase();
    int st, da, s0;
    s0 = n_snoop;
    setup(16'd10, 16'h40, 16'd2);          // 1 word, drive -> memory
    run_phase(st, da);
    chk("R12", st >= 4000, 1, "stall held through sweep");
    chk("R8", bmem[8'h40], 16'hFFFF, "swept drive word");
    chk("R9", n_snoop - s0, 1, "snoop count");
  endtask

  task automatic t_write_to_drive();
    logic [15:0] d; logic h; int s0;
    for (int i = 0; i < 6; i++) bmem[8'h10 + i] = 16'hA000 + 16'(i) * 16'h0111;
    wait_cfg = 0; s0 = n_snoop;
    setup(16'd100, 16'h10, 16'((6 << 1) | 1));
    expect_phase("R5", 4, 0);
    reg_rd(16'd0, d, h);
    chk("R4", d, 16'((2 << 1) | 1), "control after first burst");
    reg_rd(16'd1, d, h);
    chk("R7", d, 16'd104, "drive pointer");
    reg_rd(16'd2, d, h);
    chk("R7", d, 16'h14, "memory pointer");
    chk("R9", n_snoop - s0, 0, "no snoop toward drive");
    expect_phase("R5", 2, 0);
    reg_rd(16'd0, d, h);
    chk("R4", d, 16'd1, "control at completion");
  endtask

  task automatic t_read_with_waits();
    logic [15:0] d; logic h; int s0, b0;
    wait_cfg = 2; s0 = n_snoop; b0 = n_snoop_bad;
    setup(16'd100, 16'h80, 16'(6 << 1));
    expect_phase("R11", 4, 2);
    expect_phase("R11", 2, 2);
    for (int i = 0; i < 6; i++)
      chk("R3", bmem[8'h80 + i], 16'hA000 + 16'(i) * 16'h0111, "drive data in memory");
    chk("R9", n_snoop - s0, 6, "snoop per memory write");
    chk("R9", n_snoop_bad - b0, 0, "snoop address match");
    reg_rd(16'd0, d, h);
    chk("R4", d, 16'd0, "read transfer complete");
    wait_cfg = 0;
  endtask

  task automatic t_zero_count();
    int st, da, mw0, mr0;
    mw0 = n_memwr; mr0 = n_memrd;
    run_phase(st, da);
    chk("R6", da, 0, "done in first cycle");
    chk("R6", st, 0, "no stall");
    chk("R6", (n_memwr - mw0) + (n_memrd - mr0), 0, "no words");
  endtask

  task automatic t_wrap();
    logic [15:0] d; logic h;
    for (int i = 0; i < 3; i++) bmem[8'h20 + i] = 16'h5000 + 16'(i);
    setup(16'd4094, 16'h20, 16'((3 << 1) | 1));
    expect_phase("R7", 3, 0);
    reg_rd(16'd1, d, h);
    chk("R7", d, 16'd1, "drive pointer wrapped");
    reg_rd(16'd2, d, h);
    chk("R7", d, 16'h23, "memory pointer after wrap");
    setup(16'd4094, 16'hA0, 16'(3 << 1));
    expect_phase("R7", 3, 0);
    for (int i = 0; i < 3; i++)
      chk("R7", bmem[8'hA0 + i], 16'h5000 + 16'(i), "wrapped drive data");
  endtask

  task automatic t_locked_write();
    logic [15:0] d; logic h; bit done = 0;
    wait_cfg = 3;
    setup(16'd100, 16'hC0, 16'(2 << 1));
    @(negedge clk); irq_phase = 1;
    @(negedge clk); irq_phase = 0;
    cpu_req = 1; cpu_we = 1; cpu_addr = 16'd0; cpu_wdata = 16'h7FFF;
    @(negedge clk); cpu_req = 0; cpu_we = 0;
    for (int c = 0; c < 100 && !done; c++) begin
      #1;
      if (phase_done) done = 1;
      @(negedge clk);
    end
    chk("R10", done, 1, "burst finished");
    reg_rd(16'd0, d, h);
    chk("R10", d, 16'd0, "control write during burst ignored");
    chk("R10", bmem[8'hC1], 16'hA111, "second word moved");
    wait_cfg = 0;
  endtask

  task automatic t_decode();
    logic [15:0] d; logic h;
    for (int a = 0; a < 3; a++) begin
      reg_rd(16'(a), d, h);
      chk("R2", h, 1, "hit on engine address");
    end
    reg_rd(16'd3, d, h);
    chk("R2", h, 0, "no hit at address 3");
    reg_rd(16'h0100, d, h);
    chk("R2", h, 0, "no hit high address");
    reg_wr(16'd1, 16'hF123);
    reg_rd(16'd1, d, h);
    chk("R2", d, 16'h0123, "drive pointer 12 bits");
    reg_wr(16'd2, 16'h1234);
    reg_wr(16'd3, 16'hBEEF);
    reg_rd(16'd2, d, h);
    chk("R2", d, 16'h1234, "memory pointer kept");
    reg_rd(16'd0, d, h);
    chk("R2", d, 16'd0, "control untouched by address 3");
  endtask

  initial begin
    for (int i = 0; i < 256; i++) bmem[i] = 16'(i) ^ 16'h5A5A;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_sweep_phase();
    t_write_to_drive();
    t_read_with_waits();
    t_zero_count();
    t_wrap();
    t_locked_write();
    t_decode();
    finished = 1;
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
    end
  end

endmodule